// File: doc/BRIEF.md
# USB Host Interrupt Status Controller

This block keeps the interrupt status word and the interrupt enable word of a USB host controller and drives a single level interrupt towards the host. Four sources feed the status word. Completion of a transaction sets one flag. A failed transaction sets another. Change activity on a port owned by this controller sets a third. The fourth is a frame list rollover flag, raised when a frame index bit toggles. The list size setting picks which bit is watched.

Sources report through one-cycle event pulses. Software reaches both words through a simple register port: a select line picks the status or the enable word, and reads are combinational. Status flags are sticky. Writing a one to a status bit clears it. The interrupt output is a registered OR of the status bits that are enabled.

Top module: `usb_irq_status_ctrl`

## Requirements
- R1: After reset the status word, the enable word and `irq` are all 0.
- R2: Status bit 0 (completion) is set on the clock edge where `xact_done` is high together with `xact_ioc` or `xact_short`. `xact_done` with neither qualifier, and with no error, leaves the word at 0.
- R3: Status bit 1 (error) is set when `xact_done` and `xact_err` are high together. If `xact_ioc` is also high, bits 0 and 1 are both set on the same edge.
- R4: Status bit 2 (port change) is set when `port_change[i]` or `port_resume[i]` is high for a port whose `port_companion[i]` is 0. The same pulses on a port with `port_companion[i]`=1 have no effect.
- R5: Status bit 3 (rollover) is set on the edge after a toggle of one `frame_index` bit. The bit is 13 when `list_size`=00, 12 when it is 01, and 11 when it is 10 or 11. A toggle of any other index bit has no effect.
- R6: Status bits are recorded whatever the value of the enable word.
- R7: Writing the status word (`reg_sel`=0) clears each bit written as 1. Bits written as 0 keep their value. Status bits never fall in any other way.
- R8: A set event and a clearing write on the same bit in the same cycle leave the bit set.
- R9: `irq` goes high one cycle after some status bit and its enable bit (`reg_sel`=1 word, same bit position) are both 1. It goes low one cycle after no such pair remains.
- R10: Bits 31..4 of both words read as 0, and writes to them are ignored.
- R11: A `frame_index` value held through reset does not produce a rollover flag once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_index | input | 14 | Current frame index |
| list_size | input | 2 | Frame list size: 00=1024, 01=512, 10=256 |
| port_change | input | 4 | Per-port change-bit-rose pulses |
| port_resume | input | 4 | Per-port forced-resume pulses |
| port_companion | input | 4 | 1 = port handed to a companion controller |
| xact_done | input | 1 | Transaction completed this cycle |
| xact_ioc | input | 1 | Descriptor carried interrupt-on-complete |
| xact_short | input | 1 | Short packet received |
| xact_err | input | 1 | Transaction ended with an error |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status word, 1 = enable word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest case to reach from the ports is a set event and a clearing write landing on the same bit in the same cycle. A sequential write task cannot line these up, so the bench raises the event pulse and the write strobe together in one cycle and then reads the bit back. The rollover tap is also hard to exercise, because the tap moves with `list_size`. The bench toggles the watched bit and a neighbouring bit for each size, and it holds a nonzero index through reset to show that releasing reset raises no false flag.

// File: rtl/usbirq_pkg.sv
// Shared constants and types of the USB host interrupt status controller.
package usbirq_pkg;
    localparam int NUM_SRC     = 4;
    localparam int DATA_W      = 32;
    localparam int FIDX_W      = 14;
    localparam int BIT_DONE    = 0;
    localparam int BIT_ERR     = 1;
    localparam int BIT_PORT    = 2;
    localparam int BIT_ROLL    = 3;
    // Highest frame index bit watched (1024-entry list); smaller lists step down.
    localparam int TAP_HI      = 13;
    localparam int TAP_N       = 3;
    localparam int TAP_LO      = TAP_HI - TAP_N + 1;

    typedef enum logic [1:0] {
        LIST_1024 = 2'b00,
        LIST_512  = 2'b01,
        LIST_256  = 2'b10,
        LIST_RSVD = 2'b11
    } list_size_e;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/usbirq_rollover.sv
// Frame list rollover detector.
// Watches the frame index bits that can mark a wrap and pulses when the bit
// picked by the list size toggles. Assumes the index moves at most once per
// cycle. The previous-value register also loads during reset, so a reset
// release never looks like a toggle.
module usbirq_rollover
    import usbirq_pkg::*;
(
    input  logic             clk,
    input  logic [TAP_N-1:0] tap,       // frame_index[TAP_HI:TAP_LO]
    input  list_size_e       list_size,
    output logic             roll
);
    logic [TAP_N-1:0] prev_q;
    logic [1:0]       sel;

    // Remember last cycle's tap bits, reset or not.
    always_ff @(posedge clk) begin
        prev_q <= tap;
    end

    // Pick the watched bit: 1024 -> top tap, 512 -> next, others -> lowest.
    always_comb begin
        unique case (list_size)
            LIST_1024: sel = 2'd2;
            LIST_512:  sel = 2'd1;
            default:   sel = 2'd0;
        endcase
    end

    // Toggle of the watched bit is a rollover.
    assign roll = tap[sel] ^ prev_q[sel];
endmodule

// File: rtl/usbirq_events.sv
// Event qualifier: turns raw source pulses into per-flag set requests.
// Purely combinational. Assumes every input is a single-cycle pulse.
module usbirq_events
    import usbirq_pkg::*;
#(
    parameter int NUM_PORTS = 4
)(
    input  logic [NUM_PORTS-1:0] port_change,
    input  logic [NUM_PORTS-1:0] port_resume,
    input  logic [NUM_PORTS-1:0] port_companion,
    input  logic                 xact_done,
    input  logic                 xact_ioc,
    input  logic                 xact_short,
    input  logic                 xact_err,
    input  logic                 roll,
    output logic [NUM_SRC-1:0]   set_vec
);
    logic [NUM_PORTS-1:0] port_hit;

    // Only ports owned by this controller report changes.
    assign port_hit = (port_change | port_resume) & ~port_companion;

    // Map qualified events onto status bit positions.
    always_comb begin
        set_vec           = '0;
        set_vec[BIT_DONE] = xact_done & (xact_ioc | xact_short);
        set_vec[BIT_ERR]  = xact_done & xact_err;
        set_vec[BIT_PORT] = |port_hit;
        set_vec[BIT_ROLL] = roll;
    end
endmodule

// File: rtl/usbirq_regs.sv
// Status and enable registers plus the registered interrupt level.
// Status bits are sticky, cleared by writing one, and a set wins over a clear
// in the same cycle. Assumes set_vec holds single-cycle requests.
module usbirq_regs
    import usbirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic               wr,
    input  reg_sel_e           sel,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] status_q,
    output logic [NUM_SRC-1:0] enable_q,
    output logic               irq_q
);
    logic [NUM_SRC-1:0] clr_vec;

    // Write-one-to-clear mask, active only on status writes.
    assign clr_vec = (wr && sel == SEL_STATUS) ? wdata : '0;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_stat
        // One sticky flag: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          status_q[i] <= 1'b0;
            else if (set_vec[i]) status_q[i] <= 1'b1;
            else if (clr_vec[i]) status_q[i] <= 1'b0;
        end
    end

    // Enable word loads on enable writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                        enable_q <= '0;
        else if (wr && sel == SEL_ENABLE)  enable_q <= wdata;
    end

    // Interrupt level follows enabled active flags one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_q & enable_q);
    end

    // A requested set is visible next cycle even against a clear.
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // A clear with no competing set empties the cleared bits.
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

    // Flags fall only where a clear was written.
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_vec)) == '0));

    // Enabled active flag raises the line next cycle.
    assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & enable_q) != '0) |=> irq_q);

    // No enabled active flag drops the line next cycle.
    assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & enable_q) == '0) |=> !irq_q);
endmodule

// File: rtl/usb_irq_status_ctrl.sv
// USB host interrupt status controller top.
// Joins the rollover detector, event qualifier and register bank and serves
// combinational reads. Reserved bits read as zero and ignore writes.
module usb_irq_status_ctrl
    import usbirq_pkg::*;
#(
    parameter int NUM_PORTS = 4
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FIDX_W-1:0]    frame_index,
    input  logic [1:0]           list_size,
    input  logic [NUM_PORTS-1:0] port_change,
    input  logic [NUM_PORTS-1:0] port_resume,
    input  logic [NUM_PORTS-1:0] port_companion,
    input  logic                 xact_done,
    input  logic                 xact_ioc,
    input  logic                 xact_short,
    input  logic                 xact_err,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq
);
    logic               roll;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] enable_q;
    reg_sel_e           sel_e;
    logic               unused_bits;

    assign sel_e       = reg_sel_e'(reg_sel);
    assign unused_bits = ^{frame_index[TAP_LO-1:0], reg_wdata[DATA_W-1:NUM_SRC]};

    usbirq_rollover u_roll (
        .clk       (clk),
        .tap       (frame_index[TAP_HI:TAP_LO]),
        .list_size (list_size_e'(list_size)),
        .roll      (roll)
    );

    usbirq_events #(.NUM_PORTS(NUM_PORTS)) u_evt (
        .port_change    (port_change),
        .port_resume    (port_resume),
        .port_companion (port_companion),
        .xact_done      (xact_done),
        .xact_ioc       (xact_ioc),
        .xact_short     (xact_short),
        .xact_err       (xact_err),
        .roll           (roll),
        .set_vec        (set_vec)
    );

    usbirq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .wr       (reg_wr),
        .sel      (sel_e),
        .wdata    (reg_wdata[NUM_SRC-1:0]),
        .status_q (status_q),
        .enable_q (enable_q),
        .irq_q    (irq)
    );

    // Read mux: selected word, reserved bits zero-filled.
    always_comb begin
        reg_rdata              = '0;
        reg_rdata[NUM_SRC-1:0] = (sel_e == SEL_ENABLE) ? enable_q : status_q;
    end
endmodule

// File: tb/sim_usb_irq_status_ctrl.sv
module sim_usb_irq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] frame_index = '0;
    logic [1:0]  list_size = 2'b00;
    logic [3:0]  port_change = '0, port_resume = '0, port_companion = '0;
    logic        xact_done = 0, xact_ioc = 0, xact_short = 0, xact_err = 0;
    logic        reg_wr = 0, reg_sel = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          errors = 0, checks = 0;
    bit          done_flag = 0;

    always #10 clk = ~clk;   // 50 MHz

    usb_irq_status_ctrl u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic read_word(input logic sel, output logic [31:0] v);
        reg_sel = sel; #1 v = reg_rdata;
    endtask

    task automatic write_word(input logic sel, input logic [31:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic clear_all(); write_word(1'b0, 32'hF); endtask

    task automatic do_reset();
        rst_n = 0; step(); step(); step(); rst_n = 1; step();
    endtask

    task automatic xact(input logic ioc, input logic shrt, input logic err);
        xact_done = 1; xact_ioc = ioc; xact_short = shrt; xact_err = err;
        step();
        xact_done = 0; xact_ioc = 0; xact_short = 0; xact_err = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        read_word(0, v); check("R1 status", v, 0);
        read_word(1, v); check("R1 enable", v, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_complete();
        logic [31:0] v;
        xact(1, 0, 0); read_word(0, v); check("R2 ioc", v, 32'h1);
        clear_all();   read_word(0, v); check("R7 clear", v, 0);
        xact(0, 0, 0); read_word(0, v); check("R2 plain done", v, 0);
        xact(0, 1, 0); read_word(0, v); check("R2 short", v, 32'h1);
        clear_all();
    endtask

    task automatic t_error();
        logic [31:0] v;
        xact(0, 0, 1); read_word(0, v); check("R3 err", v, 32'h2);
        clear_all();
        xact(1, 0, 1); read_word(0, v); check("R3 err+ioc", v, 32'h3);
        clear_all();
    endtask

    task automatic t_port();
        logic [31:0] v;
        port_companion = 4'b0100;
        port_change = 4'b0100; step(); port_change = 0;
        read_word(0, v); check("R4 companion ignored", v, 0);
        port_change = 4'b0010; step(); port_change = 0;
        read_word(0, v); check("R4 change", v, 32'h4);
        clear_all();
        port_resume = 4'b1000; step(); port_resume = 0;
        read_word(0, v); check("R4 resume", v, 32'h4);
        clear_all(); port_companion = 0;
    endtask

    task automatic roll_case(input logic [1:0] sz, input int hit, input int miss);
        logic [31:0] v;
        list_size = sz; step();
        frame_index[miss] = ~frame_index[miss]; step();
        read_word(0, v); check($sformatf("R5 size%0d other bit%0d", sz, miss), v, 0);
        frame_index[hit] = ~frame_index[hit]; step();
        read_word(0, v); check($sformatf("R5 size%0d bit%0d", sz, hit), v, 32'h8);
        clear_all();
    endtask

    task automatic t_roll();
        roll_case(2'b00, 13, 12);
        roll_case(2'b01, 12, 13);
        roll_case(2'b10, 11, 12);
        roll_case(2'b11, 11, 10);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        xact(1, 0, 0);
        read_word(0, v); check("R6 status w/o enable", v, 32'h1);
        step(); check("R6 irq stays low", irq, 0);
        write_word(1, 32'h1); check("R9 irq not yet", irq, 0);
        step(); check("R9 irq high", irq, 1);
        clear_all(); check("R9 irq one more cycle", irq, 1);
        step(); check("R9 irq low after clear", irq, 0);
        xact(1, 0, 0); step(); check("R9 irq high again", irq, 1);
        write_word(1, 32'h0); check("R9 irq held", irq, 1);
        step(); check("R9 irq low after disable", irq, 0);
        clear_all();
    endtask

    task automatic t_wins();
        logic [31:0] v;
        xact(0, 0, 1);
        xact_done = 1; xact_err = 1;
        reg_wr = 1; reg_sel = 0; reg_wdata = 32'h3;
        step();
        xact_done = 0; xact_err = 0; reg_wr = 0; reg_wdata = 0;
        read_word(0, v); check("R8 set beats clear", v, 32'h2);
        write_word(0, 32'h0); read_word(0, v); check("R7 write zero keeps", v, 32'h2);
        clear_all();
    endtask

    task automatic t_rsvd();
        logic [31:0] v;
        write_word(1, 32'hFFFF_FFFF); read_word(1, v); check("R10 enable upper", v, 32'hF);
        xact(1, 0, 1);
        write_word(0, 32'hFFFF_FFF0); read_word(0, v); check("R10 status upper", v, 32'h3);
        write_word(1, 32'h0); clear_all();
    endtask

    task automatic t_arm();
        logic [31:0] v;
        list_size = 2'b00;
        rst_n = 0; step(); frame_index = 14'h2800; step(); step();
        rst_n = 1; step(); step();
        read_word(0, v); check("R11 no flag after reset", v, 0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_complete();
        t_error();
        t_port();
        t_roll();
        t_irq();
        t_wins();
        t_rsvd();
        t_arm();
        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule